// File: doc/BRIEF.md
# Sequenced Colour Lookup Table Loader

This block holds a 256-entry colour lookup table, each entry a 24-bit red/green/blue triple, and gives the host a small register window through which the table is loaded. The host first writes an entry number to the index register. It then writes the data register three times, once for each colour component. Each write stores one component of the selected entry. A component sequencer remembers which colour is next. Once the blue component has been written, the entry number steps forward by one, so a run of consecutive entries can be loaded with an uninterrupted stream of data writes.

In both registers the useful byte is the most significant byte of the 32-bit write word. The other bits are ignored. The pixel pipeline has a separate lookup port. It presents an entry number and receives that entry's colour one clock later. Host reads of the window always return zero. The sequencer therefore cannot be read back, and the table is only observed through the lookup port.

Top module: `clut_port`

## Requirements
- R1: After reset, lookup of every entry returns 24'h000000 except entry 255, which returns 24'hFFFFFF; the index and the sequencer are cleared, so the first data write without an index write lands in the red component of entry 0.
- R2: A full-word write (host_be = 4'hF) at host_addr 4'h0 sets the current entry to host_wdata[31:24].
- R3: Full-word writes at host_addr 4'h4 store host_wdata[31:24] into the current entry, in the order red, green, blue; on lut_rgb red is bits 23:16, green bits 15:8 and blue bits 7:0, and host_wdata[23:0] has no effect.
- R4: The data write that stores blue advances the current entry by one modulo 256 (255 wraps to 0) and returns the sequencer to red.
- R5: lut_rgb shows the entry presented on lut_idx one cycle earlier; a component written at clock edge E is visible on lut_rgb after edge E+1 and not after edge E.
- R6: host_rdata is zero at all times, and host reads do not change the index, the sequencer or the table.
- R7: Writes whose host_addr is neither 4'h0 nor 4'h4 change neither the table, the index nor the sequencer.
- R8: Writes with any host_be bit clear are ignored at every offset.
- R9: An index write made partway through a triple restarts the sequencer at red for the newly selected entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one write per cycle, no wait states |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 4 | Byte offset inside the 16-byte window |
| host_be | input | 4 | Byte enables; only 4'hF is accepted |
| host_wdata | input | 32 | Host write data; bits 31:24 carry the index or component |
| host_rdata | output | 32 | Host read data, always zero |
| lut_idx | input | 8 | Entry number presented by the pixel pipeline |
| lut_rgb | output | 24 | Colour of the entry presented one cycle earlier |

## Verification
A write takes effect at the edge that samples it. Because the lookup port adds one register, a changed component reaches lut_rgb one edge after that. The bench drives every input on the falling edge and samples lut_rgb one full cycle after it changes lut_idx. For R5 it samples both after the write edge, where the old colour must still show, and one edge later, where the new one must. Ignored writes (R6, R7, R8) are always followed by a complete triple, so a disturbed index or sequencer shows up as a colour in the wrong entry or in the wrong component.

// File: rtl/clut_pkg.sv
`timescale 1ns/1ps
package clut_pkg;
    localparam int unsigned OFS_INDEX = 0;
    localparam int unsigned OFS_DATA  = 4;

    typedef enum logic [1:0] {
        CMP_RED = 2'd0,
        CMP_GRN = 2'd1,
        CMP_BLU = 2'd2
    } comp_e;
endpackage

// File: rtl/clut_seq.sv
`timescale 1ns/1ps
module clut_seq
    import clut_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8,
    parameter int CH_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [3:0]        host_be,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [IDX_W-1:0]  seq_idx,
    output comp_e             seq_comp,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output comp_e             wr_comp,
    output logic [CH_W-1:0]   wr_val
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        comp_e            comp;
    } seq_t;

    seq_t st_d, st_q;
    logic full_wr, sel_idx, sel_dat;
    logic unused_low;

    assign unused_low = ^host_wdata[DATA_W-CH_W-1:0];

    always_comb begin
        st_d    = st_q;
        full_wr = host_wr && (&host_be);
        sel_idx = full_wr && (host_addr == ADDR_W'(OFS_INDEX));
        sel_dat = full_wr && (host_addr == ADDR_W'(OFS_DATA));
        wr_en   = 1'b0;
        if (sel_idx) begin
            st_d.idx  = host_wdata[DATA_W-1 -: IDX_W];
            st_d.comp = CMP_RED;
        end else if (sel_dat) begin
            wr_en = 1'b1;
            case (st_q.comp)
                CMP_RED: st_d.comp = CMP_GRN;
                CMP_GRN: st_d.comp = CMP_BLU;
                default: begin
                    st_d.comp = CMP_RED;
                    st_d.idx  = st_q.idx + 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{idx: '0, comp: CMP_RED};
        end else begin
            st_q <= st_d;
        end
    end

    assign seq_idx  = st_q.idx;
    assign seq_comp = st_q.comp;
    assign wr_idx   = st_q.idx;
    assign wr_comp  = st_q.comp;
    assign wr_val   = host_wdata[DATA_W-1 -: CH_W];
endmodule

// File: rtl/clut_store.sv
`timescale 1ns/1ps
module clut_store
    import clut_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int CH_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  comp_e             wr_comp,
    input  logic [CH_W-1:0]   wr_val,
    input  logic [IDX_W-1:0]  lut_idx,
    output logic [3*CH_W-1:0] lut_rgb
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int RGB_W   = 3 * CH_W;

    logic [RGB_W-1:0] mem_q [ENTRIES];
    logic [RGB_W-1:0] ent_d;
    logic [RGB_W-1:0] rgb_d, rgb_q;

    always_comb begin
        ent_d = mem_q[wr_idx];
        case (wr_comp)
            CMP_RED: ent_d[RGB_W-1 -: CH_W]  = wr_val;
            CMP_GRN: ent_d[2*CH_W-1 -: CH_W] = wr_val;
            default: ent_d[CH_W-1:0]         = wr_val;
        endcase
        rgb_d = mem_q[lut_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem_q[i] <= (i == ENTRIES - 1) ? {RGB_W{1'b1}} : {RGB_W{1'b0}};
            end
            rgb_q <= '0;
        end else begin
            if (wr_en) begin
                mem_q[wr_idx] <= ent_d;
            end
            rgb_q <= rgb_d;
        end
    end

    assign lut_rgb = rgb_q;
endmodule

// File: rtl/clut_port.sv
`timescale 1ns/1ps
module clut_port
    import clut_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8,
    parameter int CH_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [3:0]        host_be,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [IDX_W-1:0]  lut_idx,
    output logic [3*CH_W-1:0] lut_rgb
);
    logic [IDX_W-1:0] seq_idx;
    comp_e            seq_comp;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    comp_e            wr_comp;
    logic [CH_W-1:0]  wr_val;
    logic             unused_rd;

    assign unused_rd  = host_rd;
    assign host_rdata = '0;

    clut_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .CH_W(CH_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (host_wr),
        .host_addr (host_addr),
        .host_be   (host_be),
        .host_wdata(host_wdata),
        .seq_idx   (seq_idx),
        .seq_comp  (seq_comp),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_comp   (wr_comp),
        .wr_val    (wr_val)
    );

    clut_store #(
        .IDX_W(IDX_W), .CH_W(CH_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_comp(wr_comp),
        .wr_val (wr_val),
        .lut_idx(lut_idx),
        .lut_rgb(lut_rgb)
    );
endmodule

// File: rtl/clut_port_chk.sv
`timescale 1ns/1ps
module clut_port_chk
    import clut_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic [3:0]        host_be,
    input logic [DATA_W-1:0] host_wdata,
    input logic [IDX_W-1:0]  seq_idx,
    input logic [1:0]        seq_comp
);
    logic full_wr, is_idx, is_dat;
    assign full_wr = host_wr && (host_be == 4'hF);
    assign is_idx  = full_wr && (host_addr == ADDR_W'(OFS_INDEX));
    assign is_dat  = full_wr && (host_addr == ADDR_W'(OFS_DATA));

    p_idx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_idx |=> (seq_idx == $past(host_wdata[DATA_W-1 -: IDX_W])));

    p_restart_red_r9: assert property (@(posedge clk) disable iff (!rst_n)
        is_idx |=> (seq_comp == 2'd0));

    p_red_to_green_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_dat && seq_comp == 2'd0) |=> (seq_comp == 2'd1 && $stable(seq_idx)));

    p_green_to_blue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_dat && seq_comp == 2'd1) |=> (seq_comp == 2'd2 && $stable(seq_idx)));

    p_blue_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_dat && seq_comp == 2'd2) |=>
            (seq_comp == 2'd0 && seq_idx == IDX_W'($past(seq_idx) + 1'b1)));

    p_bad_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr != ADDR_W'(OFS_INDEX) && host_addr != ADDR_W'(OFS_DATA))
            |=> ($stable(seq_idx) && $stable(seq_comp)));

    p_partial_be_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_be != 4'hF) |=> ($stable(seq_idx) && $stable(seq_comp)));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr) |=> ($stable(seq_idx) && $stable(seq_comp)));

    p_comp_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seq_comp != 2'd3);
endmodule

bind clut_port clut_port_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .host_be   (host_be),
    .host_wdata(host_wdata),
    .seq_idx   (seq_idx),
    .seq_comp  (seq_comp)
);

// File: tb/tb_clut_port.sv
`timescale 1ns/1ps
module tb_clut_port;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_wr, host_rd;
    logic [3:0]  host_addr, host_be;
    logic [31:0] host_wdata, host_rdata;
    logic [7:0]  lut_idx;
    logic [23:0] lut_rgb;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [23:0] m_tab [256];
    logic [7:0]  m_idx;
    int          m_cmp;

    always #2.5 clk = ~clk;

    clut_port dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_be(host_be), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .lut_idx(lut_idx), .lut_rgb(lut_rgb)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_be = be; host_wdata = d;
        if (be == 4'hF && a == 4'h0) begin
            m_idx = d[31:24]; m_cmp = 0;
        end else if (be == 4'hF && a == 4'h4) begin
            case (m_cmp)
                0: m_tab[m_idx][23:16] = d[31:24];
                1: m_tab[m_idx][15:8]  = d[31:24];
                default: m_tab[m_idx][7:0] = d[31:24];
            endcase
            if (m_cmp == 2) begin m_cmp = 0; m_idx = m_idx + 8'd1; end
            else m_cmp = m_cmp + 1;
        end
        @(negedge clk);
        host_wr = 1'b0; host_be = 4'h0; host_wdata = '0;
    endtask

    task automatic do_rd(input logic [3:0] a, input string req);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 check(req, host_rdata, 32'h0);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic look(input logic [7:0] i, input string req);
        @(negedge clk);
        lut_idx = i;
        @(negedge clk);
        check(req, {8'h0, lut_rgb}, {8'h0, m_tab[i]});
    endtask

    task automatic triple(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
        do_wr(4'h4, 4'hF, {r, 24'hA5A5A5});
        do_wr(4'h4, 4'hF, {g, 24'h5A5A5A});
        do_wr(4'h4, 4'hF, {b, 24'hFFFFFF});
    endtask

    task automatic t_reset();
        look(8'd0,   "R1 entry0");
        look(8'd1,   "R1 entry1");
        look(8'd128, "R1 entry128");
        look(8'd254, "R1 entry254");
        look(8'd255, "R1 entry255 white");
        check("R1 white value", {8'h0, lut_rgb}, 32'h00FFFFFF);
        do_wr(4'h4, 4'hF, 32'h7E000000);
        look(8'd0, "R1 first data write lands red of entry0");
        check("R1 red of entry0", {8'h0, lut_rgb}, 32'h007E0000);
    endtask

    task automatic t_triple();
        do_wr(4'h0, 4'hF, 32'h10FFFFFF);
        triple(8'h12, 8'h34, 8'h56);
        look(8'h10, "R3 triple order");
        check("R2 R3 entry 0x10", {8'h0, lut_rgb}, 32'h00123456);
        triple(8'h9A, 8'hBC, 8'hDE);
        look(8'h11, "R4 autoincrement to 0x11");
        look(8'h10, "R4 entry 0x10 kept");
    endtask

    task automatic t_wrap();
        do_wr(4'h0, 4'hF, 32'hFF000000);
        triple(8'h01, 8'h02, 8'h03);
        triple(8'h44, 8'h55, 8'h66);
        look(8'hFF, "R4 entry 255 written");
        look(8'h00, "R4 wrap to entry 0");
        check("R4 wrap value", {8'h0, lut_rgb}, 32'h00445566);
    endtask

    task automatic t_restart();
        do_wr(4'h0, 4'hF, 32'h20000000);
        do_wr(4'h4, 4'hF, 32'hAA000000);
        do_wr(4'h4, 4'hF, 32'hBB000000);
        do_wr(4'h0, 4'hF, 32'h20000000);
        triple(8'h11, 8'h22, 8'h33);
        look(8'h20, "R9 restart at red");
        check("R9 value", {8'h0, lut_rgb}, 32'h00112233);
        look(8'h21, "R9 next entry untouched");
    endtask

    task automatic t_ignore();
        do_wr(4'h0, 4'hF, 32'h30000000);
        do_wr(4'h4, 4'hF, 32'hC1000000);
        do_wr(4'h8, 4'hF, 32'hEE000000);
        do_wr(4'hC, 4'hF, 32'hEE000000);
        do_wr(4'h2, 4'hF, 32'h99000000);
        do_wr(4'h5, 4'hF, 32'h99000000);
        look(8'h30, "R7 bad offsets ignored");
        do_wr(4'h4, 4'h7, 32'hEE000000);
        do_wr(4'h0, 4'hE, 32'h77000000);
        look(8'h30, "R8 partial byte enables ignored");
        do_wr(4'h4, 4'hF, 32'hC2000000);
        do_wr(4'h4, 4'hF, 32'hC3000000);
        look(8'h30, "R7 R8 sequence intact");
        check("R7 R8 entry 0x30", {8'h0, lut_rgb}, 32'h00C1C2C3);
        look(8'h77, "R8 no entry 0x77 write");
    endtask

    task automatic t_read();
        do_wr(4'h0, 4'hF, 32'h50000000);
        do_wr(4'h4, 4'hF, 32'hD1000000);
        do_rd(4'h0, "R6 read offset0 zero");
        do_rd(4'h4, "R6 read offset4 zero");
        do_rd(4'h8, "R6 read offset8 zero");
        do_wr(4'h4, 4'hF, 32'hD2000000);
        do_wr(4'h4, 4'hF, 32'hD3000000);
        look(8'h50, "R6 reads leave sequencer");
        check("R6 entry 0x50", {8'h0, lut_rgb}, 32'h00D1D2D3);
        check("R6 rdata idle", host_rdata, 32'h0);
    endtask

    task automatic t_latency();
        logic [23:0] old;
        do_wr(4'h0, 4'hF, 32'h40000000);
        @(negedge clk); lut_idx = 8'h40;
        @(negedge clk);
        old = m_tab[8'h40];
        do_wr(4'h4, 4'hF, 32'h9A000000);
        check("R5 old value after write edge", {8'h0, lut_rgb}, {8'h0, old});
        @(negedge clk);
        check("R5 new value one edge later", {8'h0, lut_rgb}, {8'h0, m_tab[8'h40]});
        check("R5 new red", {8'h0, lut_rgb}, 32'h009A0000);
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) m_tab[i] = (i == 255) ? 24'hFFFFFF : 24'h0;
        m_idx = 8'd0; m_cmp = 0;
        rst_n = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
        host_addr = '0; host_be = '0; host_wdata = '0; lut_idx = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check("R6 rdata after reset", host_rdata, 32'h0);
        t_reset();
        t_triple();
        t_wrap();
        t_restart();
        t_ignore();
        t_read();
        t_latency();
        repeat (2) @(negedge clk);
        report();
    end

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        report();
    end
endmodule